// File: doc/BRIEF.md
# CAN Transmit Slot Sequencer

This block keeps the transmit-side flags of a bank of message slots in a CAN controller and decides which slot goes onto the bus next. Each slot holds four bits: a transmit request, an interrupt enable, an active bit and a completion bit. Software writes the request, enable and completion bits of one slot per write cycle. The hardware owns the active bit and sets the completion bit.

The bus side is kept simple. It reports a bus-idle level and single-cycle pulses for start of frame, lost arbitration and error-free end of frame. When the bus is idle, the sequencer takes the lowest-numbered eligible slot and marks it active. It raises a global transmitter-state flag and pulses a start strobe with the slot number for the frame engine.

A lost arbitration drops the slot back to waiting, with its request still pending, so the slot is retried at the next idle. A successful frame does several things at once:
- It marks the slot complete.
- It records the slot number and raises a global success flag.
- It pulses the interrupt output if the slot allows it.

Software re-arms a completed slot with a fixed handshake. It first clears both the completion and request bits. Only after it reads both back as 0 does it set the request bit again.

Top module: `can_txslot_seq`

## Requirements
- R1: After reset every slot's request, completion, active and enable bits are 0, and the transmitter-state flag, the success flag, the last-slot field, the start strobe and the interrupt are all 0.
- R2: A slot is eligible when its request is 1 and its completion and active bits are 0. When the sequencer is idle, bus_idle is 1 and some slot is eligible, the next clock edge does all of the following: sets that slot's active bit, sets trm_state_o, clears tx_succ_o, drives tx_slot_o with the slot number and raises tx_go_o for exactly one cycle.
- R3: When several slots are eligible at a start, the lowest-numbered one is chosen.
- R4: An arb_lost pulse after the start-of-frame pulse clears the slot's active bit and trm_state_o at the next edge and leaves its request at 1. The slot then starts again at the next bus idle.
- R5: Between the start strobe and the start-of-frame pulse, arb_lost and eof_ok pulses are ignored: the active bit stays 1 and the completion bit stays 0.
- R6: An eof_ok pulse after start of frame does all of the following at the next edge: sets the slot's completion bit, clears its active bit, loads last_slot_o with the slot number and sets tx_succ_o. trm_state_o stays 1.
- R7: On that success edge irq_o is 1 for exactly one cycle if the slot's enable bit is 1, and stays 0 if the enable bit is 0.
- R8: A slot whose completion bit is 1 never starts. A host write of request 1 to that slot is ignored, and its request keeps its old value.
- R9: A host write (host_we, with host_slot as the slot index) loads that slot's request and enable bits from host_req and host_ie. host_done = 0 clears the completion bit, and host_done = 1 leaves it unchanged.
- R10: If a host write to a slot lands in the same cycle as that slot's success, the completion bit ends at 1. The request takes the written value.
- R11: After a success, the first cycle with bus_idle = 1 clears trm_state_o without starting a slot. A slot re-armed by the handshake can start at the bus idle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe for one slot |
| host_slot | input | SLOT_W (4) | Slot index of the host write |
| host_req | input | 1 | Request value written |
| host_done | input | 1 | Completion value written (only 0 takes effect) |
| host_ie | input | 1 | Interrupt enable value written |
| bus_idle | input | 1 | Bus is idle (level) |
| bus_sof | input | 1 | Start of frame pulse |
| bus_arb_lost | input | 1 | Arbitration lost pulse |
| bus_eof_ok | input | 1 | Error-free end of frame pulse |
| req_o | output | NUM_SLOTS (16) | Per-slot request bits |
| done_o | output | NUM_SLOTS (16) | Per-slot completion bits |
| active_o | output | NUM_SLOTS (16) | Per-slot active bits |
| trm_state_o | output | 1 | Transmitter-state flag |
| tx_go_o | output | 1 | One-cycle start strobe to the frame engine |
| tx_slot_o | output | SLOT_W (4) | Slot being sent |
| last_slot_o | output | SLOT_W (4) | Last slot sent successfully |
| tx_succ_o | output | 1 | Success flag |
| irq_o | output | 1 | Successful-transmission interrupt pulse |

## Verification
Two things can touch a slot's flags in the same cycle: the hardware's success update and a host write to that same slot. The bench raises eof_ok and a host write to the sending slot on the same clock edge. It then checks that the completion bit ends at 1 while the request takes the written value. The bench also lines up a host write that sets a request against a completion bit that is still set, and checks that the request is not accepted.

// File: rtl/can_txslot_pkg.sv
package can_txslot_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_SEND   = 2'd2,
      SQ_IFS    = 2'd3
   } sq_state_e;

endpackage

// File: rtl/can_txslot_flags.sv
module can_txslot_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wr_req,
   input  logic wr_done,
   input  logic wr_ie,
   input  logic hw_start,
   input  logic hw_clr_active,
   input  logic hw_succ,
   output logic req,
   output logic done,
   output logic active,
   output logic ie
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         ie  <= 1'b0;
      end else if (wr_hit) begin
         ie <= wr_ie;
         if (!(wr_req && done)) req <= wr_req;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  done <= 1'b0;
      else if (hw_succ)            done <= 1'b1;
      else if (wr_hit && !wr_done) done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             active <= 1'b0;
      else if (hw_start)      active <= 1'b1;
      else if (hw_clr_active) active <= 1'b0;
   end

   a_r8_done_excludes_active: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && active));
   a_r10_success_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hw_succ |=> done);
   a_r8_no_rearm_while_done: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_req && done && !req) |=> !req);

endmodule

// File: rtl/can_txslot_pick.sv
module can_txslot_pick #(
   parameter int N     = 16,
   parameter int SEL_W = 4
) (
   input  logic [N-1:0]     elig,
   output logic             any,
   output logic [SEL_W-1:0] idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i]) begin
            any = 1'b1;
            idx = i[SEL_W-1:0];
         end
      end
   end

endmodule

// File: rtl/can_txslot_fsm.sv
module can_txslot_fsm
   import can_txslot_pkg::*;
#(
   parameter int N     = 16,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_idle,
   input  logic             bus_sof,
   input  logic             bus_arb_lost,
   input  logic             bus_eof_ok,
   input  logic             any_elig,
   input  logic [SEL_W-1:0] pick_idx,
   input  logic [N-1:0]     ie_vec,
   output logic             start,
   output logic             clr_active,
   output logic             succ,
   output logic [SEL_W-1:0] cur_slot,
   output logic             trm_state,
   output logic             tx_go,
   output logic [SEL_W-1:0] last_slot,
   output logic             tx_succ,
   output logic             irq
);

   sq_state_e st;

   assign start      = (st == SQ_IDLE) && bus_idle && any_elig;
   assign clr_active = (st == SQ_SEND) && (bus_arb_lost || bus_eof_ok);
   assign succ       = (st == SQ_SEND) && bus_eof_ok && !bus_arb_lost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         cur_slot  <= '0;
         trm_state <= 1'b0;
         tx_go     <= 1'b0;
         last_slot <= '0;
         tx_succ   <= 1'b0;
         irq       <= 1'b0;
      end else begin
         tx_go <= 1'b0;
         irq   <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  cur_slot  <= pick_idx;
                  trm_state <= 1'b1;
                  tx_succ   <= 1'b0;
                  tx_go     <= 1'b1;
                  st        <= SQ_LAUNCH;
               end
            end
            SQ_LAUNCH: begin
               if (bus_sof) st <= SQ_SEND;
            end
            SQ_SEND: begin
               if (bus_arb_lost) begin
                  trm_state <= 1'b0;
                  st        <= SQ_IDLE;
               end else if (bus_eof_ok) begin
                  last_slot <= cur_slot;
                  tx_succ   <= 1'b1;
                  irq       <= ie_vec[cur_slot];
                  st        <= SQ_IFS;
               end
            end
            SQ_IFS: begin
               if (bus_idle) begin
                  trm_state <= 1'b0;
                  st        <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   a_r2_start_raises_state: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (trm_state && tx_go && !tx_succ));
   a_r2_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |=> !tx_go);
   a_r4_arb_drops_state: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_SEND && bus_arb_lost) |=> !trm_state);
   a_r5_launch_waits_sof: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_LAUNCH && !bus_sof) |=> (st == SQ_LAUNCH && trm_state));
   a_r6_success_record: assert property (@(posedge clk) disable iff (!rst_n)
      succ |=> (tx_succ && trm_state && last_slot == $past(cur_slot)));
   a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r11_ifs_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IFS && bus_idle) |=> (!trm_state && !tx_go));

endmodule

// File: rtl/can_txslot_seq.sv
module can_txslot_seq #(
   parameter int NUM_SLOTS = 16,
   parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic [SLOT_W-1:0]    host_slot,
   input  logic                 host_req,
   input  logic                 host_done,
   input  logic                 host_ie,
   input  logic                 bus_idle,
   input  logic                 bus_sof,
   input  logic                 bus_arb_lost,
   input  logic                 bus_eof_ok,
   output logic [NUM_SLOTS-1:0] req_o,
   output logic [NUM_SLOTS-1:0] done_o,
   output logic [NUM_SLOTS-1:0] active_o,
   output logic                 trm_state_o,
   output logic                 tx_go_o,
   output logic [SLOT_W-1:0]    tx_slot_o,
   output logic [SLOT_W-1:0]    last_slot_o,
   output logic                 tx_succ_o,
   output logic                 irq_o
);

   localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);

   initial begin : p_param_check
      assert (NUM_SLOTS >= 2) else $fatal(1, "NUM_SLOTS must be at least 2");
      assert ((1 << SLOT_W) >= NUM_SLOTS) else $fatal(1, "SLOT_W too narrow");
   end

   logic [NUM_SLOTS-1:0] ie_vec;
   logic [NUM_SLOTS-1:0] elig;
   logic                 any_elig;
   logic [SLOT_W-1:0]    pick_idx;
   logic                 start;
   logic                 clr_active;
   logic                 succ;
   logic [SLOT_W-1:0]    cur_slot;

   assign elig = req_o & ~done_o & ~active_o;

   can_txslot_pick #(.N(NUM_SLOTS), .SEL_W(SLOT_W)) u_pick (
      .elig (elig),
      .any  (any_elig),
      .idx  (pick_idx)
   );

   can_txslot_fsm #(.N(NUM_SLOTS), .SEL_W(SLOT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_idle     (bus_idle),
      .bus_sof      (bus_sof),
      .bus_arb_lost (bus_arb_lost),
      .bus_eof_ok   (bus_eof_ok),
      .any_elig     (any_elig),
      .pick_idx     (pick_idx),
      .ie_vec       (ie_vec),
      .start        (start),
      .clr_active   (clr_active),
      .succ         (succ),
      .cur_slot     (cur_slot),
      .trm_state    (trm_state_o),
      .tx_go        (tx_go_o),
      .last_slot    (last_slot_o),
      .tx_succ      (tx_succ_o),
      .irq          (irq_o)
   );

   assign tx_slot_o = cur_slot;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam logic [SLOT_W-1:0] IDX = SLOT_W'(g);
      logic hit;
      assign hit = host_we && (host_slot == IDX);

      can_txslot_flags u_flags (
         .clk           (clk),
         .rst_n         (rst_n),
         .wr_hit        (hit),
         .wr_req        (host_req),
         .wr_done       (host_done),
         .wr_ie         (host_ie),
         .hw_start      (start && (pick_idx == IDX)),
         .hw_clr_active (clr_active && (cur_slot == IDX)),
         .hw_succ       (succ && (cur_slot == IDX)),
         .req           (req_o[g]),
         .done          (done_o[g]),
         .active        (active_o[g]),
         .ie            (ie_vec[g])
      );
   end

   a_r2_single_active: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(active_o));
   a_r3_lowest_chosen: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ((elig & ((ONE << pick_idx) - ONE)) == '0 && elig[pick_idx]));
   a_r2_active_matches_slot: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go_o |-> (active_o == (ONE << tx_slot_o)));

endmodule

// File: tb/sim_can_txslot_seq.sv
module sim_can_txslot_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [3:0]  host_slot = '0;
   logic        host_req = 1'b0, host_done = 1'b0, host_ie = 1'b0;
   logic        bus_idle = 1'b0, bus_sof = 1'b0, bus_arb_lost = 1'b0, bus_eof_ok = 1'b0;
   logic [15:0] req_o, done_o, active_o;
   logic        trm_state_o, tx_go_o, tx_succ_o, irq_o;
   logic [3:0]  tx_slot_o, last_slot_o;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   can_txslot_seq u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_slot(host_slot),
      .host_req(host_req), .host_done(host_done), .host_ie(host_ie),
      .bus_idle(bus_idle), .bus_sof(bus_sof), .bus_arb_lost(bus_arb_lost),
      .bus_eof_ok(bus_eof_ok), .req_o(req_o), .done_o(done_o), .active_o(active_o),
      .trm_state_o(trm_state_o), .tx_go_o(tx_go_o), .tx_slot_o(tx_slot_o),
      .last_slot_o(last_slot_o), .tx_succ_o(tx_succ_o), .irq_o(irq_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(int s, bit r, bit d, bit e);
      host_we = 1'b1; host_slot = s[3:0];
      host_req = r; host_done = d; host_ie = e;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic clear_all();
      for (int i = 0; i < 16; i++) wr(i, 0, 0, 0);
   endtask

   task automatic idle_cycle();
      bus_idle = 1'b1; @(negedge clk); bus_idle = 1'b0;
   endtask

   task automatic p_sof();
      bus_sof = 1'b1; @(negedge clk); bus_sof = 1'b0;
   endtask

   task automatic p_arb();
      bus_arb_lost = 1'b1; @(negedge clk); bus_arb_lost = 1'b0;
   endtask

   task automatic p_eof();
      bus_eof_ok = 1'b1; @(negedge clk); bus_eof_ok = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : main
      logic [15:0] bit_s;
      repeat (3) @(negedge clk);
      // R1: state after reset
      chk("R1 req", req_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 active", active_o, 0);
      chk("R1 trm", trm_state_o, 0);
      chk("R1 succ/irq/go", {tx_succ_o, irq_o, tx_go_o}, 0);
      chk("R1 last", last_slot_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int s = 0; s < 16; s++) begin
         bit e;
         e = s[0];
         bit_s = 16'(1) << s;
         clear_all();
         wr(s, 1, 0, e);
         chk("R9 request written", req_o, bit_s);
         idle_cycle();
         chk("R2 active", active_o, bit_s);
         chk("R2 trm", trm_state_o, 1);
         chk("R2 go", tx_go_o, 1);
         chk("R2 slot", tx_slot_o, s);
         chk("R2 succ cleared", tx_succ_o, 0);
         @(negedge clk);
         chk("R2 go single", tx_go_o, 0);
         if (s == 3) begin
            p_eof();
            p_arb();
            chk("R5 active kept", active_o, bit_s);
            chk("R5 done kept", done_o, 0);
         end
         p_sof();
         p_eof();
         chk("R6 done", done_o, bit_s);
         chk("R6 active clear", active_o, 0);
         chk("R6 last", last_slot_o, s);
         chk("R6 succ", tx_succ_o, 1);
         chk("R6 trm held", trm_state_o, 1);
         chk("R7 irq", irq_o, e);
         @(negedge clk);
         chk("R7 irq single", irq_o, 0);
         idle_cycle();
         chk("R11 trm released", trm_state_o, 0);
         chk("R11 no start", tx_go_o, 0);
         idle_cycle();
         chk("R8 done slot stays idle", active_o, 0);
         wr(s, 0, 1, e);
         chk("R9 done write 1 keeps", done_o, bit_s);
         chk("R9 request cleared", req_o, 0);
         wr(s, 1, 1, e);
         chk("R8 request ignored", req_o, 0);
         wr(s, 0, 0, e);
         chk("R9 done cleared", done_o, 0);
         wr(s, 1, 0, e);
         idle_cycle();
         chk("R11 rearmed start", active_o, bit_s);
         p_sof();
         p_arb();
         chk("R4 active clear", active_o, 0);
         chk("R4 trm clear", trm_state_o, 0);
         chk("R4 request kept", req_o, bit_s);
         idle_cycle();
         chk("R4 retry", active_o, bit_s);
         chk("R4 retry slot", tx_slot_o, s);
         p_sof();
         p_eof();
         idle_cycle();
      end

      // R10: success and host write to the same slot in one cycle
      clear_all();
      wr(5, 1, 0, 1);
      idle_cycle();
      p_sof();
      bus_eof_ok = 1'b1;
      host_we = 1'b1; host_slot = 4'd5; host_req = 1'b0; host_done = 1'b0; host_ie = 1'b1;
      @(negedge clk);
      bus_eof_ok = 1'b0; host_we = 1'b0;
      chk("R10 done wins", done_o, 16'h0020);
      chk("R10 request written", req_o, 0);
      chk("R10 irq", irq_o, 1);
      idle_cycle();

      // R3: priority sweep over many request patterns
      for (int k = 1; k <= 24; k++) begin
         logic [15:0] m;
         int lo;
         m = 16'((k * 40503) ^ (k << 7));
         if (m == 0) m = 16'h8000;
         lo = -1;
         for (int i = 15; i >= 0; i--) if (m[i]) lo = i;
         clear_all();
         for (int i = 0; i < 16; i++) if (m[i]) wr(i, 1, 0, 0);
         idle_cycle();
         chk("R3 lowest slot", tx_slot_o, lo);
         chk("R3 lowest active", active_o, 16'(1) << lo);
         p_sof();
         p_arb();
      end

      summary();
      $finish;
   end

endmodule